// File: doc/BRIEF.md
# Instruction Fetch Address Watchpoint Unit

This unit watches the address of every instruction fetch and raises debug flags when the address meets programmed conditions. Four comparators each test the fetch address against their own reference value. Each comparator uses one of four relations. Comparators 0 and 1 can be joined into a pair, and so can comparators 2 and 3. A joined pair tests whether the address lies inside or outside a window.

The comparator results, after pairing, are called terms. They feed an AND-OR network. The network makes four watchpoint flags and one breakpoint flag. Three of the watchpoints are also driven to dedicated pin outputs. The outputs are registered, so the flags for a fetch appear on the next cycle. The unit accepts a new fetch address on every cycle and never holds the fetch pipeline back.

Top module: `fetch_watch_unit`

## Requirements
- R1: Comparator k uses mode bits `cmp_mode_i[2k+1:2k]` and reference `cmp_ref_i[32k+31:32k]`. The mode codes are 00 for address equal to reference, 01 for not equal, 10 for address greater than reference and 11 for address less than reference. All comparisons are unsigned.
- R2: When `cmp_en_i[k]` is 0, comparator k's result is false for every address and mode.
- R3: Pair 0 is comparators 0 and 1, and pair 1 is comparators 2 and 3. When `pair_en_i[p]` is 1, the pair's combined result replaces both term 2p and term 2p+1. When it is 0, each term is the result of its own comparator.
- R4: When `pair_out_i[p]` is 0, the combined result is the AND of the two comparator results (in range). When it is 1, the combined result is the OR of the two results (out of range).
- R5: Watchpoint w is true when its mask `wp_mask_i[4w+3:4w]` is nonzero and every term whose mask bit is set is true. Mask bit k selects term k. An all-zero mask never asserts.
- R6: The breakpoint is true when `bp_en_i` is 1 and at least one watchpoint selected by `bp_mask_i` (bit w selects watchpoint w) is true.
- R7: `wp_o` and `bp_o` show the result for the inputs present at the previous rising clock edge, on every cycle and with no stall. When `fetch_valid_i` was 0 at that edge, both outputs are zero.
- R8: `wp_pin_o` always equals `wp_o[2:0]`.
- R9: While `rst_ni` is low, all outputs are zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| fetch_valid_i | input | 1 | A fetch address is present this cycle |
| fetch_addr_i | input | 32 | Fetch address |
| cmp_en_i | input | 4 | Enable for each comparator |
| cmp_mode_i | input | 8 | Two mode bits per comparator |
| cmp_ref_i | input | 128 | Reference value for each comparator |
| pair_en_i | input | 2 | Joins each comparator pair |
| pair_out_i | input | 2 | Per pair: 0 selects in range, 1 selects out of range |
| wp_mask_i | input | 16 | AND mask over the four terms, one per watchpoint |
| bp_en_i | input | 1 | Breakpoint enable |
| bp_mask_i | input | 4 | OR mask over the watchpoints for the breakpoint |
| wp_o | output | 4 | Watchpoint flags |
| wp_pin_o | output | 3 | Watchpoint pin outputs |
| bp_o | output | 1 | Breakpoint flag |

## Verification
The unit keeps only the output register, so any wrong state shows up at the ports on the cycle after the fetch that caused it. A faulty relation, a swapped pair operator or a wrong mask bit shows up as a wrong watchpoint bit. Because the breakpoint is built from the watchpoints, the same fault can also show up on the breakpoint. A missing valid gate shows up as a flag during an idle cycle. The bench compares every output against a behavioural model on every cycle. It uses both directed boundary cases and narrow-range random addresses, so that hits are frequent.

// File: rtl/fw_pkg.sv
package fw_pkg;
  typedef enum logic [1:0] {
    CMP_EQ = 2'b00,
    CMP_NE = 2'b01,
    CMP_GT = 2'b10,
    CMP_LT = 2'b11
  } cmp_mode_e;
endpackage

// File: rtl/fw_cmp.sv
module fw_cmp #(
  parameter int ADDR_W = 32
) (
  input  logic              en_i,
  input  logic [1:0]        mode_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [ADDR_W-1:0] ref_i,
  output logic              hit_o
);
  fw_pkg::cmp_mode_e mode;
  logic raw;

  assign mode = fw_pkg::cmp_mode_e'(mode_i);

  always_comb begin
    unique case (mode)
      fw_pkg::CMP_EQ: raw = (addr_i == ref_i);
      fw_pkg::CMP_NE: raw = (addr_i != ref_i);
      fw_pkg::CMP_GT: raw = (addr_i >  ref_i);
      fw_pkg::CMP_LT: raw = (addr_i <  ref_i);
      default:        raw = 1'b0;
    endcase
  end

  assign hit_o = en_i & raw;
endmodule

// File: rtl/fw_pair.sv
module fw_pair #(
  parameter int N_CMP  = 4,
  localparam int N_PAIR = N_CMP / 2
) (
  input  logic [N_CMP-1:0]  hit_i,
  input  logic [N_PAIR-1:0] pair_en_i,
  input  logic [N_PAIR-1:0] pair_out_i,
  output logic [N_CMP-1:0]  term_o
);
  for (genvar p = 0; p < N_PAIR; p++) begin : g_pair
    logic comb;
    // out-of-range: either bound tripped; in-range: both bounds met
    assign comb = pair_out_i[p] ? (hit_i[2*p] | hit_i[2*p+1])
                                : (hit_i[2*p] & hit_i[2*p+1]);
    assign term_o[2*p]   = pair_en_i[p] ? comb : hit_i[2*p];
    assign term_o[2*p+1] = pair_en_i[p] ? comb : hit_i[2*p+1];
  end
endmodule

// File: rtl/fw_and_or.sv
module fw_and_or #(
  parameter int N_TERM = 4,
  parameter int N_WP   = 4
) (
  input  logic [N_TERM-1:0]      term_i,
  input  logic [N_WP*N_TERM-1:0] wp_mask_i,
  input  logic                   bp_en_i,
  input  logic [N_WP-1:0]        bp_mask_i,
  output logic [N_WP-1:0]        wp_o,
  output logic                   bp_o
);
  for (genvar w = 0; w < N_WP; w++) begin : g_wp
    logic [N_TERM-1:0] sel;
    assign sel     = wp_mask_i[w*N_TERM +: N_TERM];
    assign wp_o[w] = (|sel) & (&(term_i | ~sel));
  end

  assign bp_o = bp_en_i & (|(wp_o & bp_mask_i));
endmodule

// File: rtl/fetch_watch_unit.sv
module fetch_watch_unit #(
  parameter int ADDR_W = 32,
  parameter int N_CMP  = 4,
  parameter int N_WP   = 4,
  parameter int N_PIN  = 3,
  localparam int N_PAIR = N_CMP / 2
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic                    fetch_valid_i,
  input  logic [ADDR_W-1:0]       fetch_addr_i,
  input  logic [N_CMP-1:0]        cmp_en_i,
  input  logic [2*N_CMP-1:0]      cmp_mode_i,
  input  logic [N_CMP*ADDR_W-1:0] cmp_ref_i,
  input  logic [N_PAIR-1:0]       pair_en_i,
  input  logic [N_PAIR-1:0]       pair_out_i,
  input  logic [N_WP*N_CMP-1:0]   wp_mask_i,
  input  logic                    bp_en_i,
  input  logic [N_WP-1:0]         bp_mask_i,
  output logic [N_WP-1:0]         wp_o,
  output logic [N_PIN-1:0]        wp_pin_o,
  output logic                    bp_o
);
  logic [N_CMP-1:0] hit, term;
  logic [N_WP-1:0]  wp_d, wp_q;
  logic             bp_d, bp_q;

  for (genvar k = 0; k < N_CMP; k++) begin : g_cmp
    fw_cmp #(.ADDR_W(ADDR_W)) u_cmp (
      .en_i  (cmp_en_i[k]),
      .mode_i(cmp_mode_i[2*k +: 2]),
      .addr_i(fetch_addr_i),
      .ref_i (cmp_ref_i[k*ADDR_W +: ADDR_W]),
      .hit_o (hit[k])
    );
  end

  fw_pair #(.N_CMP(N_CMP)) u_pair (
    .hit_i     (hit),
    .pair_en_i (pair_en_i),
    .pair_out_i(pair_out_i),
    .term_o    (term)
  );

  fw_and_or #(.N_TERM(N_CMP), .N_WP(N_WP)) u_and_or (
    .term_i   (term),
    .wp_mask_i(wp_mask_i),
    .bp_en_i  (bp_en_i),
    .bp_mask_i(bp_mask_i),
    .wp_o     (wp_d),
    .bp_o     (bp_d)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      wp_q <= '0;
      bp_q <= 1'b0;
    end else if (fetch_valid_i) begin
      wp_q <= wp_d;
      bp_q <= bp_d;
    end else begin
      wp_q <= '0;
      bp_q <= 1'b0;
    end
  end

  assign wp_o     = wp_q;
  assign bp_o     = bp_q;
  assign wp_pin_o = wp_q[N_PIN-1:0];

  AST_IDLE_CLEAR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !fetch_valid_i |=> (wp_o == '0) && !bp_o); // R7

  AST_BP_NEEDS_EN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_o |-> $past(bp_en_i)); // R6

  AST_BP_FROM_WP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bp_o |-> |(wp_o & $past(bp_mask_i))); // R6

  for (genvar w = 0; w < N_WP; w++) begin : g_ast
    AST_WP_MASK_SET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      wp_o[w] |-> $past(wp_mask_i[w*N_CMP +: N_CMP]) != '0); // R5
  end
endmodule

// File: tb/fetch_watch_unit_tb.sv
module fetch_watch_unit_tb_top;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        valid;
  logic [31:0] addr;
  logic [3:0]  cen;
  logic [7:0]  cmode;
  logic [127:0] cref;
  logic [1:0]  pen, pout;
  logic [15:0] wmask;
  logic        ben;
  logic [3:0]  bmask;
  logic [3:0]  wp;
  logic [2:0]  pin;
  logic        bp;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  fetch_watch_unit dut_i (
    .clk_i(clk), .rst_ni(rst_n), .fetch_valid_i(valid), .fetch_addr_i(addr),
    .cmp_en_i(cen), .cmp_mode_i(cmode), .cmp_ref_i(cref), .pair_en_i(pen),
    .pair_out_i(pout), .wp_mask_i(wmask), .bp_en_i(ben), .bp_mask_i(bmask),
    .wp_o(wp), .wp_pin_o(pin), .bp_o(bp)
  );

  task automatic summary();
    $display("%0d/%0d checks passed", checks - fails, checks);
  endtask

  initial begin
    #(CLK_P * 100000);
    fails++; checks++;
    $display("FAIL R7 watchdog expired act=hung exp=done");
    summary();
    $finish;
  end

  // behavioural reference
  task automatic model(output logic [3:0] ew, output logic eb);
    bit h[4];
    bit t[4];
    ew = '0; eb = 1'b0;
    if (!valid) return;
    for (int k = 0; k < 4; k++) begin
      longint unsigned a = addr;
      longint unsigned r = cref[32*k +: 32];
      int m = cmode[2*k +: 2];
      bit rel;
      if (m == 0) rel = (a == r);
      else if (m == 1) rel = (a != r);
      else if (m == 2) rel = (a > r);
      else rel = (a < r);
      h[k] = cen[k] && rel;
      t[k] = h[k];
    end
    for (int p = 0; p < 2; p++)
      if (pen[p]) begin
        bit c = pout[p] ? (h[2*p] || h[2*p+1]) : (h[2*p] && h[2*p+1]);
        t[2*p] = c; t[2*p+1] = c;
      end
    for (int w = 0; w < 4; w++) begin
      int nsel = 0;
      bit ok = 1;
      for (int k = 0; k < 4; k++)
        if (wmask[4*w+k]) begin
          nsel++;
          if (!t[k]) ok = 0;
        end
      ew[w] = (nsel > 0) && ok;
      if (ben && bmask[w] && ew[w]) eb = 1'b1;
    end
  endtask

  task automatic check(string tag, logic [3:0] ew, logic eb);
    checks++;
    if (wp !== ew) begin
      fails++;
      $display("FAIL %s wp_o act=%b exp=%b", tag, wp, ew);
    end
    checks++;
    if (bp !== eb) begin
      fails++;
      $display("FAIL %s bp_o act=%b exp=%b", tag, bp, eb);
    end
    checks++;
    if (pin !== wp[2:0]) begin
      fails++;
      $display("FAIL R8 wp_pin_o act=%b exp=%b", pin, wp[2:0]);
    end
  endtask

  // inputs are set; evaluate, cross one edge, compare at the next falling edge
  task automatic run(string tag);
    logic [3:0] ew;
    logic eb;
    model(ew, eb);
    @(negedge clk);
    check(tag, ew, eb);
  endtask

  task automatic set_cmp(int k, logic en, logic [1:0] m, logic [31:0] rv);
    cen[k] = en;
    cmode[2*k +: 2] = m;
    cref[32*k +: 32] = rv;
  endtask

  task automatic clear_cfg();
    cen = '0; cmode = '0; cref = '0; pen = '0; pout = '0;
    wmask = '0; ben = 1'b0; bmask = '0;
  endtask

  initial begin
    rst_n = 1'b0; valid = 1'b1; addr = 32'h10; clear_cfg();
    set_cmp(0, 1'b1, 2'b00, 32'h10); wmask = 16'h0001; ben = 1'b1; bmask = 4'h1;
    @(negedge clk); @(negedge clk);
    check("R9", 4'h0, 1'b0);
    rst_n = 1'b1;
    clear_cfg();

    // R1: each relation, unsigned
    wmask = 16'h0001; valid = 1'b1;
    set_cmp(0, 1'b1, 2'b00, 32'h1234); addr = 32'h1234; run("R1");
    addr = 32'h1235; run("R1");
    set_cmp(0, 1'b1, 2'b01, 32'h1234); run("R1");
    addr = 32'h1234; run("R1");
    set_cmp(0, 1'b1, 2'b10, 32'h1234); addr = 32'h1235; run("R1");
    addr = 32'h1234; run("R1");
    set_cmp(0, 1'b1, 2'b11, 32'h1234); addr = 32'h1233; run("R1");
    addr = 32'h1234; run("R1");
    set_cmp(0, 1'b1, 2'b10, 32'h1); addr = 32'h8000_0000; run("R1");
    set_cmp(0, 1'b1, 2'b11, 32'h1); run("R1");

    // R2: disabled comparator never hits
    set_cmp(0, 1'b0, 2'b01, 32'h0); addr = 32'h55; run("R2");
    set_cmp(0, 1'b0, 2'b00, 32'h55); run("R2");

    // R3/R4: in range on pair 0
    clear_cfg();
    set_cmp(0, 1'b1, 2'b10, 32'h100); set_cmp(1, 1'b1, 2'b11, 32'h200);
    pen = 2'b01; wmask = 16'h0021;
    addr = 32'h150; run("R4");
    addr = 32'h250; run("R4");
    addr = 32'h50;  run("R4");
    pen = 2'b00; addr = 32'h250; run("R3");
    // out of range on pair 1
    clear_cfg();
    set_cmp(2, 1'b1, 2'b11, 32'h100); set_cmp(3, 1'b1, 2'b10, 32'h200);
    pen = 2'b10; pout = 2'b10; wmask = 16'h0C00 | 16'h0040;
    addr = 32'h50;  run("R4");
    addr = 32'h150; run("R4");
    addr = 32'h300; run("R4");
    pen = 2'b00; addr = 32'h50; run("R3");

    // R5: AND masks
    clear_cfg();
    set_cmp(2, 1'b1, 2'b00, 32'hABC); set_cmp(3, 1'b1, 2'b01, 32'h777);
    wmask = 16'h0C00; addr = 32'hABC; run("R5");
    addr = 32'h777; run("R5");
    set_cmp(3, 1'b1, 2'b01, 32'hABC); addr = 32'hABC; run("R5");
    wmask = 16'h0000; set_cmp(3, 1'b1, 2'b01, 32'h1); run("R5");

    // R6: breakpoint OR
    wmask = 16'h0C00; bmask = 4'b0100; ben = 1'b0; run("R6");
    ben = 1'b1; run("R6");
    bmask = 4'b1011; run("R6");
    bmask = 4'b1111; wmask = 16'h0C04; run("R6");

    // R7: idle gating and back-to-back results
    valid = 1'b0; run("R7");
    valid = 1'b1; run("R7");
    valid = 1'b0; run("R7");
    addr = 32'h0; valid = 1'b1; run("R7");

    // randomised sweep over narrow ranges
    for (int i = 0; i < 600; i++) begin
      valid = ($urandom_range(0, 7) != 0);
      addr  = $urandom_range(0, 15);
      cen   = 4'($urandom);
      cmode = 8'($urandom);
      for (int k = 0; k < 4; k++) cref[32*k +: 32] = $urandom_range(0, 15);
      pen   = 2'($urandom);
      pout  = 2'($urandom);
      wmask = 16'($urandom);
      ben   = 1'($urandom);
      bmask = 4'($urandom);
      run("R7");
    end

    summary();
    $finish;
  end
endmodule